// File: doc/BRIEF.md
# Converter Output Bus Demultiplexer and Formatter

This block is the digital back end of a pipelined sampling converter. Once per encode clock it takes one raw sample word and its out-of-range flag, carries them through a fixed-latency delay line, applies the selected number format and places the result on one or two output buses. The bus arrangement is chosen by a 2-bit select. In full-rate mode every sample goes to bus A. In the two half-rate modes the samples alternate between bus A and bus B, and the buses either change together or take turns.

Each bus carries its own overflow flag, and the block drives two data-valid clocks. The output enables are brought out as plain signals rather than high-impedance values, so a pad ring or a wrapper can attach the tri-state drivers. A power-down input and an output-disable input together select one of four states. In the run state the outputs are driven. In the quiet state the pipeline keeps running with the outputs off. In nap and sleep the pipeline freezes and the outputs are off. After a freeze, no output is enabled again until it carries a sample captured after the resume.

Top module: `adc_demux_formatter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the pipeline and the bus phase. After reset `bus_a_oe`, `bus_b_oe`, `vclk_a` and `vclk_b` are all low.
- R2: With `out_mode` 2'b00 or 2'b11 (full rate), the word and flag sampled at edge k appear on `bus_a`/`ovr_a` after edge k+5, and bus A takes a new word at every running edge.
- R3: With `out_mode` 2'b01 (paired update), the edges after reset are numbered from 0, and both buses load together on odd-numbered edges. Bus A takes the sample from 5 edges earlier and bus B the sample from 6 edges earlier. Bus A therefore carries the samples taken on even-numbered edges, and bus B carries the earlier sample of each pair.
- R4: With `out_mode` 2'b10 (alternating update), bus A loads on odd-numbered edges and bus B on even-numbered edges, each with the sample from 5 edges earlier. Samples taken on even edges go to A and samples taken on odd edges go to B, and each bus holds its word for two cycles.
- R5: `vclk_a` is high after odd-numbered edges and low after even-numbered edges, and `vclk_b` is always its complement. Bus A loads as `vclk_a` rises, so a receiver latches it on the falling edge of `vclk_a`. Bus B is latched on the rising edge of `vclk_b` in paired mode and on the falling edge in alternating mode.
- R6: With `fmt_twos` = 0 the word passes unchanged (offset binary). With `fmt_twos` = 1, bit W-1 of the word is inverted (two's complement). The format in force at the edge where a bus loads applies to that word.
- R7: `ovr_a` and `ovr_b` each equal the out-of-range flag that was sampled together with the word on the same bus.
- R8: Power state decode uses {`pwr_dn`,`out_dis`}. 00 is run: outputs enabled. 01 is quiet: the pipeline advances and every enable is low, `vclk_oe` included. 10 is nap and 11 is sleep: the pipeline freezes and every enable is low.
- R9: Leaving the quiet state for run enables the outputs immediately, with current data and no refill.
- R10: A nap or sleep edge invalidates every word held in the pipeline. After the resume, a bus is enabled only once it holds a sample captured after the resume. In full rate this means `bus_a_oe` returns high after the sixth edge that follows the resume.
- R11: In full rate `bus_b_oe` stays low while `vclk_b` keeps toggling and `vclk_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encode clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_data | input | W | Raw sample word |
| smp_ovr | input | 1 | Out-of-range flag of the sample |
| out_mode | input | 2 | Bus arrangement: 00 full, 01 paired, 10 alternating, 11 full (differential) |
| fmt_twos | input | 1 | 1 selects two's complement, 0 offset binary |
| pwr_dn | input | 1 | Power-down request |
| out_dis | input | 1 | Output disable |
| bus_a | output | W | Bus A word |
| ovr_a | output | 1 | Bus A overflow flag |
| vclk_a | output | 1 | Bus A data-valid clock |
| bus_a_oe | output | 1 | Drive enable for bus A word and flag |
| bus_b | output | W | Bus B word |
| ovr_b | output | 1 | Bus B overflow flag |
| vclk_b | output | 1 | Bus B data-valid clock |
| bus_b_oe | output | 1 | Drive enable for bus B word and flag |
| vclk_oe | output | 1 | Drive enable for both valid clocks |

## Verification
Random words with random flags and random format are streamed in each of the four arrangements. Comparing the bus contents against the sample history tells apart a latency that is off by one, buses that are swapped, and the wrong pairing parity between A and B. Ramp streams whose value equals the edge number make the pairing visible directly, and the corner values 0, mid-scale and full-scale expose the MSB inversion. Random stretches of quiet, nap and sleep are mixed in, together with directed resumes, to separate a pipeline that freezes and refills from one that keeps running or shows stale words.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;

  typedef enum logic [1:0] {
    OM_FULL  = 2'b00,
    OM_PAIR  = 2'b01,
    OM_ALT   = 2'b10,
    OM_DIFF  = 2'b11
  } out_mode_e;

  typedef enum logic [1:0] {
    PS_RUN   = 2'b00,
    PS_QUIET = 2'b01,
    PS_NAP   = 2'b10,
    PS_SLEEP = 2'b11
  } pwr_state_e;

  // {power-down, output-disable} -> power state
  function automatic pwr_state_e decode_pwr(input logic dn, input logic dis);
    case ({dn, dis})
      2'b00:   return PS_RUN;
      2'b01:   return PS_QUIET;
      2'b10:   return PS_NAP;
      default: return PS_SLEEP;
    endcase
  endfunction

  function automatic logic is_split(input logic [1:0] mode);
    return (mode == OM_PAIR) || (mode == OM_ALT);
  endfunction

endpackage

// File: rtl/adcfmt_power_ctl.sv
module adcfmt_power_ctl
  import adcfmt_pkg::*;
(
  input  logic       pwr_dn,
  input  logic       out_dis,
  input  logic [1:0] out_mode,
  output logic       advance,
  output logic       drive,
  output logic       split
);
  pwr_state_e state;

  always_comb begin
    state   = decode_pwr(pwr_dn, out_dis);
    advance = (state == PS_RUN) || (state == PS_QUIET);
    drive   = (state == PS_RUN);
    split   = is_split(out_mode);
  end
endmodule

// File: rtl/adcfmt_delay_line.sv
module adcfmt_delay_line #(
  parameter int SW  = 12,
  parameter int LAT = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance,
  input  logic [SW-1:0] din,
  output logic [SW-1:0] tail,
  output logic [SW-1:0] tail_d
);
  localparam int VB = SW - 1;  // freshness bit

  logic [LAT-1:0][SW-1:0] line;
  logic [SW-1:0]          tail_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line     <= '0;
      tail_d_q <= '0;
    end else if (!advance) begin
      for (int i = 0; i < LAT; i++) line[i][VB] <= 1'b0;
      tail_d_q[VB] <= 1'b0;
    end else begin
      line[0] <= din;
      for (int i = 1; i < LAT; i++) line[i] <= line[i-1];
      tail_d_q <= line[LAT-1];
    end
  end

  assign tail   = line[LAT-1];
  assign tail_d = tail_d_q;
endmodule

// File: rtl/adcfmt_bus_steer.sv
module adcfmt_bus_steer
  import adcfmt_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         advance,
  input  logic [1:0]   out_mode,
  input  logic         fmt_twos,
  input  logic [W+1:0] tail,
  input  logic [W+1:0] tail_d,
  output logic [W+1:0] a_q,
  output logic [W+1:0] b_q,
  output logic         vclk_a,
  output logic         vclk_b,
  output logic         load_a,
  output logic         load_b
);
  localparam int SW = W + 2;
  localparam int VB = SW - 1;

  logic          ph;
  logic [SW-1:0] b_src;

  // Offset binary to two's complement: flip the word MSB only.
  function automatic logic [SW-1:0] fmt_word(input logic [SW-1:0] w, input logic twos);
    logic [SW-1:0] r;
    r        = w;
    r[W-1]   = w[W-1] ^ twos;
    return r;
  endfunction

  always_comb begin
    load_a = advance && (is_split(out_mode) ? ph : 1'b1);
    load_b = advance && (((out_mode == OM_PAIR) && ph) ||
                         ((out_mode == OM_ALT) && !ph));
    b_src  = (out_mode == OM_PAIR) ? tail_d : tail;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= 1'b0;
      vclk_a <= 1'b0;
      vclk_b <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
    end else begin
      ph     <= ~ph;
      vclk_a <= ph;
      vclk_b <= ~ph;
      if (!advance) begin
        a_q[VB] <= 1'b0;
        b_q[VB] <= 1'b0;
      end else begin
        if (load_a) a_q <= fmt_word(tail, fmt_twos);
        if (load_b) b_q <= fmt_word(b_src, fmt_twos);
      end
    end
  end
endmodule

// File: rtl/adc_demux_formatter.sv
module adc_demux_formatter #(
  parameter int W   = 10,
  parameter int LAT = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] smp_data,
  input  logic         smp_ovr,
  input  logic [1:0]   out_mode,
  input  logic         fmt_twos,
  input  logic         pwr_dn,
  input  logic         out_dis,
  output logic [W-1:0] bus_a,
  output logic         ovr_a,
  output logic         vclk_a,
  output logic         bus_a_oe,
  output logic [W-1:0] bus_b,
  output logic         ovr_b,
  output logic         vclk_b,
  output logic         bus_b_oe,
  output logic         vclk_oe
);
  localparam int SW = W + 2;
  localparam int VB = SW - 1;

  logic          advance, drive, split;
  logic          load_a, load_b;
  logic [SW-1:0] din, tail, tail_d, a_q, b_q;

  assign din = {1'b1, smp_ovr, smp_data};

  adcfmt_power_ctl i_pwr (
    .pwr_dn   (pwr_dn),
    .out_dis  (out_dis),
    .out_mode (out_mode),
    .advance  (advance),
    .drive    (drive),
    .split    (split)
  );

  adcfmt_delay_line #(.SW(SW), .LAT(LAT)) i_line (
    .clk     (clk),
    .rst     (rst),
    .advance (advance),
    .din     (din),
    .tail    (tail),
    .tail_d  (tail_d)
  );

  adcfmt_bus_steer #(.W(W)) i_steer (
    .clk      (clk),
    .rst      (rst),
    .advance  (advance),
    .out_mode (out_mode),
    .fmt_twos (fmt_twos),
    .tail     (tail),
    .tail_d   (tail_d),
    .a_q      (a_q),
    .b_q      (b_q),
    .vclk_a   (vclk_a),
    .vclk_b   (vclk_b),
    .load_a   (load_a),
    .load_b   (load_b)
  );

  assign bus_a    = a_q[W-1:0];
  assign ovr_a    = a_q[W];
  assign bus_a_oe = drive && a_q[VB];
  assign bus_b    = b_q[W-1:0];
  assign ovr_b    = b_q[W];
  assign bus_b_oe = drive && split && b_q[VB];
  assign vclk_oe  = drive;
endmodule

// File: rtl/adcfmt_checker.sv
module adcfmt_checker
  import adcfmt_pkg::*;
#(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   out_mode,
  input logic         pwr_dn,
  input logic         out_dis,
  input logic [W-1:0] bus_a,
  input logic [W-1:0] bus_b,
  input logic         bus_a_oe,
  input logic         bus_b_oe,
  input logic         vclk_a,
  input logic         vclk_b,
  input logic         vclk_oe,
  input logic         load_a,
  input logic         load_b
);

  p_vclk_compl_r5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (vclk_a != vclk_b));

  p_vclk_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    (!rst ##1 !rst) |=> (vclk_a != $past(vclk_a)));

  p_load_a_edge_r5: assert property (@(posedge clk) disable iff (rst)
    (load_a && is_split(out_mode)) |=> vclk_a);

  // R3 (paired: B loads with A) and R4 (alternating: B loads as vclk_b rises)
  p_load_b_edge_r4: assert property (@(posedge clk) disable iff (rst)
    load_b |=> ((out_mode == OM_PAIR) ? vclk_a : vclk_b));

  p_a_moves_on_vclk_r3: assert property (@(posedge clk) disable iff (rst)
    (is_split(out_mode) && !$stable(bus_a)) |-> vclk_a);

  p_b_off_full_r11: assert property (@(posedge clk) disable iff (rst)
    bus_b_oe |-> is_split(out_mode));

  p_quiet_off_r8: assert property (@(posedge clk) disable iff (rst)
    (out_dis || pwr_dn) |-> (!bus_a_oe && !bus_b_oe && !vclk_oe));

  p_nap_stale_r10: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> (!bus_a_oe && !bus_b_oe));

  p_b_static_full_r2: assert property (@(posedge clk) disable iff (rst)
    !is_split(out_mode) |-> !load_b);

  // bus_b only referenced for completeness of the observed port set
  p_b_moves_split_r4: assert property (@(posedge clk) disable iff (rst)
    (!is_split(out_mode) && !$past(rst) && $past(!is_split(out_mode))) |-> $stable(bus_b));

endmodule

bind adc_demux_formatter adcfmt_checker #(.W(W)) i_chk (.*);

// File: tb/test_adc_demux_formatter.sv
module test_adc_demux_formatter;
  localparam int W    = 10;
  localparam int HALF = 1 << (W - 1);
  localparam int FULL = 1 << W;
  localparam int LATE = 5;
  localparam int HIST = 8192;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst = 1'b1;
  logic [W-1:0] smp_data = '0;
  logic         smp_ovr = 1'b0;
  logic [1:0]   out_mode = 2'b00;
  logic         fmt_twos = 1'b0;
  logic         pwr_dn = 1'b0;
  logic         out_dis = 1'b0;
  logic [W-1:0] bus_a, bus_b;
  logic         ovr_a, ovr_b, vclk_a, vclk_b, bus_a_oe, bus_b_oe, vclk_oe;

  adc_demux_formatter #(.W(W), .LAT(LATE)) i_adc_demux_formatter (
    .clk(clk), .rst(rst), .smp_data(smp_data), .smp_ovr(smp_ovr),
    .out_mode(out_mode), .fmt_twos(fmt_twos), .pwr_dn(pwr_dn), .out_dis(out_dis),
    .bus_a(bus_a), .ovr_a(ovr_a), .vclk_a(vclk_a), .bus_a_oe(bus_a_oe),
    .bus_b(bus_b), .ovr_b(ovr_b), .vclk_b(vclk_b), .bus_b_oe(bus_b_oe),
    .vclk_oe(vclk_oe)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Reference model state, built from the requirements
  int ph, adv, epoch, a_idx, b_idx, a_val, b_val;
  bit a_ov, b_ov, m_clka, m_clkb;
  int samp [HIST];
  bit sovr [HIST];

  function automatic int fmt_ref(int raw, bit twos);
    return twos ? (raw + HALF) % FULL : raw;
  endfunction

  function automatic bit split_mode(logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  task automatic load_a(int idx);
    a_idx = idx;
    if (idx >= 0) begin
      a_val = fmt_ref(samp[idx % HIST], fmt_twos);
      a_ov  = sovr[idx % HIST];
    end
  endtask

  task automatic load_b(int idx);
    b_idx = idx;
    if (idx >= 0) begin
      b_val = fmt_ref(samp[idx % HIST], fmt_twos);
      b_ov  = sovr[idx % HIST];
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; adv = 0; epoch = 0; a_idx = -1; b_idx = -1;
      m_clka = 0; m_clkb = 0;
    end else begin
      if (pwr_dn) begin
        epoch = adv;
      end else begin
        samp[adv % HIST] = smp_data;
        sovr[adv % HIST] = smp_ovr;
        if (!split_mode(out_mode)) load_a(adv - 5);
        else if (out_mode == 2'b01) begin
          if (ph == 1) begin load_a(adv - 5); load_b(adv - 6); end
        end else begin
          if (ph == 1) load_a(adv - 5);
          else         load_b(adv - 5);
        end
        adv++;
      end
      m_clka = (ph == 1);
      m_clkb = (ph == 0);
      ph = 1 - ph;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    bit    run, ea, eb;
    string mt;
    run = !pwr_dn && !out_dis;
    mt  = (out_mode == 2'b01) ? "R3" : (out_mode == 2'b10) ? "R4" : "R2";
    ea  = run && (a_idx >= epoch);
    eb  = run && split_mode(out_mode) && (b_idx >= epoch);
    chk({mt, " R10 bus_a_oe"}, 32'(bus_a_oe), 32'(ea));
    if (ea) begin
      chk({mt, " R6 bus_a"}, 32'(bus_a), 32'(a_val));
      chk("R7 ovr_a", 32'(ovr_a), 32'(a_ov));
    end
    chk(split_mode(out_mode) ? {mt, " R10 bus_b_oe"} : "R11 bus_b_oe", 32'(bus_b_oe), 32'(eb));
    if (eb) begin
      chk({mt, " R6 bus_b"}, 32'(bus_b), 32'(b_val));
      chk("R7 ovr_b", 32'(ovr_b), 32'(b_ov));
    end
    chk("R5 vclk_a", 32'(vclk_a), 32'(m_clka));
    chk("R5 vclk_b", 32'(vclk_b), 32'(m_clkb));
    chk("R8 vclk_oe", 32'(vclk_oe), 32'(run));
  endtask

  task automatic tick();
    @(negedge clk);
    check_outputs();
  endtask

  task automatic do_reset(logic [1:0] mode);
    rst = 1'b1; out_mode = mode; pwr_dn = 1'b0; out_dis = 1'b0; fmt_twos = 1'b0;
    tick(); tick();
    chk("R1 bus_a_oe", 32'(bus_a_oe), 0);
    chk("R1 bus_b_oe", 32'(bus_b_oe), 0);
    chk("R1 vclk_a", 32'(vclk_a), 0);
    chk("R1 vclk_b", 32'(vclk_b), 0);
    rst = 1'b0;
  endtask

  function automatic logic [W-1:0] pick_word();
    int r;
    r = $urandom % 16;
    case (r)
      0:       return '0;
      1:       return W'(HALF - 1);
      2:       return W'(HALF);
      3:       return W'(FULL - 1);
      default: return W'($urandom % FULL);
    endcase
  endfunction

  task automatic run_rand(logic [1:0] mode, int n, bit pmix);
    int hold;
    hold = 0;
    do_reset(mode);
    for (int i = 0; i < n; i++) begin
      smp_data = pick_word();
      smp_ovr  = (($urandom % 8) == 0);
      fmt_twos = 1'($urandom % 2);
      if (pmix) begin
        if (hold == 0) begin
          int r;
          r = $urandom % 10;
          pwr_dn  = (r == 7) || (r == 8);
          out_dis = (r == 6) || (r == 8);
          hold = 1 + ($urandom % 8);
        end
        hold--;
      end
      tick();
    end
    pwr_dn = 1'b0; out_dis = 1'b0;
  endtask

  task automatic run_ramp(logic [1:0] mode, int n);
    do_reset(mode);
    for (int i = 0; i < n; i++) begin
      smp_data = W'(i);
      smp_ovr  = 1'b0;
      tick();
    end
  endtask

  initial begin
    int first;
    void'($urandom(32'd2024));

    for (int m = 0; m < 4; m++) run_rand(2'(m), 300, 1'b0);
    for (int m = 0; m < 4; m++) run_rand(2'(m), 500, 1'b1);

    // R3: paired update, A carries the later (even) sample, B the earlier (odd)
    run_ramp(2'b01, 20);
    chk("R3 pair spacing", 32'(bus_a - bus_b), 1);
    chk("R3 bus_b odd", 32'(bus_b % 2), 1);

    // R4: alternating update parity
    run_ramp(2'b10, 21);
    chk("R4 bus_a even", 32'(bus_a % 2), 0);
    chk("R4 bus_b odd", 32'(bus_b % 2), 1);

    // R6: MSB inversion at the corners
    do_reset(2'b00);
    fmt_twos = 1'b1; smp_data = '0;
    repeat (6) tick();
    chk("R6 zero to mid", 32'(bus_a), HALF);
    smp_data = W'(FULL - 1);
    repeat (6) tick();
    chk("R6 full to mid-1", 32'(bus_a), HALF - 1);
    fmt_twos = 1'b0;

    // R11: bus B off in full rate while its clock toggles
    do_reset(2'b11);
    repeat (8) tick();
    begin
      logic prev;
      prev = vclk_b;
      tick();
      chk("R11 vclk_b toggles", 32'(vclk_b), 32'(!prev));
      chk("R11 bus_b_oe", 32'(bus_b_oe), 0);
      chk("R11 vclk_oe", 32'(vclk_oe), 1);
    end

    // R8 / R9: quiet state keeps the pipeline filled
    out_dis = 1'b1;
    repeat (4) tick();
    chk("R8 quiet bus_a_oe", 32'(bus_a_oe), 0);
    out_dis = 1'b0;
    tick();
    chk("R9 immediate resume", 32'(bus_a_oe), 1);

    // R10: nap then refill in full rate
    pwr_dn = 1'b1;
    repeat (3) tick();
    chk("R10 nap off", 32'(bus_a_oe), 0);
    pwr_dn = 1'b0;
    first = 'h155;
    smp_data = W'(first);
    for (int i = 1; i <= 6; i++) begin
      tick();
      smp_data = W'(i);
      if (i == 5) chk("R10 still refilling", 32'(bus_a_oe), 0);
      if (i == 6) begin
        chk("R10 refilled", 32'(bus_a_oe), 1);
        chk("R10 first fresh word", 32'(bus_a), 32'(first));
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog R1-guard: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule